// File: doc/BRIEF.md
# Receiver Reset Sequencer

This block brings a serial receiver channel out of reset after power-up. It first sends a short reset pulse to the management and calibration logic. It then keeps the receiver's analog and digital resets asserted until the channel is ready to run. The analog reset is released once calibration has been idle for a programmed number of cycles. The digital reset is released once the clock-data-recovery circuit has reported lock to incoming data, without a break, for a second programmed number of cycles.

All counting is done in management-clock cycles. The two status inputs from the receiver pass through two-flop synchronizers before they are used. A synchronous restart request sends the sequence back to the calibration wait, with both receiver resets asserted again. A ready flag shows when the channel has left reset.

Top module: `rx_rst_seq`

## Requirements
- R1: While `rst_n` is low, and for exactly MGMT_CYC (≥2) clock cycles after it is released, `mgmt_rst_o` is 1. After that it stays 0.
- R2: From power-up, `ana_rst_o` and `dig_rst_o` are both 1 and `ready_o` is 0. This holds for as long as `cal_busy_i` stays 1.
- R3: Suppose `cal_busy_i` falls and then stays 0. `ana_rst_o` falls exactly ANA_WAIT+3 rising edges later. If `cal_busy_i` rises again before that, the wait starts over from its next fall.
- R4: Suppose the analog reset is already released, `cal_busy_i` is 0, and `lock_data_i` rises and then stays 1. `dig_rst_o` falls exactly LOCK_WAIT+2 rising edges after the rise.
- R5: A drop of `lock_data_i`, even for one cycle, clears the lock qualification. A lock pulse shorter than LOCK_WAIT cycles never releases `dig_rst_o`. The timing of R4 is then counted from the last rise.
- R6: `dig_rst_o` stays 1 while `cal_busy_i` is 1, even when lock has already qualified. Once lock is qualified, `dig_rst_o` falls 3 rising edges after `cal_busy_i` falls.
- R7: `lock_ref_i` has no effect on any output or on any release time.
- R8: When `reset_req_i` is 1 at a rising edge, `ana_rst_o` and `dig_rst_o` are 1 and `ready_o` is 0 after that edge. The sequence then restarts at the calibration wait, and no new `mgmt_rst_o` pulse is sent.
- R9: `ready_o` equals the inverse of `dig_rst_o` in every cycle. The analog reset never rises without the digital reset also being 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| reset_req_i | input | 1 | Synchronous restart request |
| cal_busy_i | input | 1 | Calibration in progress (asynchronous) |
| lock_data_i | input | 1 | CDR locked to data (asynchronous) |
| lock_ref_i | input | 1 | CDR locked to reference (asynchronous, ignored) |
| mgmt_rst_o | output | 1 | Reset pulse to calibration logic |
| ana_rst_o | output | 1 | Receiver analog reset |
| dig_rst_o | output | 1 | Receiver digital reset |
| ready_o | output | 1 | Receiver out of reset |

## Verification
The assertions assume that `reset_req_i` is synchronous to `clk`. They also assume that each status input, once changed, holds its new value for at least one clock, so that the synchronizer outputs follow the inputs. The stimulus changes every input one time unit after a rising edge and holds it for at least one full cycle. Random lock pulses are kept shorter than the qualification time, and random idle spans are kept between one and three cycles. This makes every release time predictable from the last input change.

// File: rtl/rx_rst_seq.sv
module rx_rst_seq #(
  parameter int MGMT_CYC  = 2,
  parameter int ANA_WAIT  = 8,
  parameter int LOCK_WAIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_req_i,
  input  logic cal_busy_i,
  input  logic lock_data_i,
  input  logic lock_ref_i,
  output logic mgmt_rst_o,
  output logic ana_rst_o,
  output logic dig_rst_o,
  output logic ready_o
);
  localparam int MAXW = (MGMT_CYC > ANA_WAIT) ?
                        ((MGMT_CYC > LOCK_WAIT) ? MGMT_CYC : LOCK_WAIT) :
                        ((ANA_WAIT > LOCK_WAIT) ? ANA_WAIT : LOCK_WAIT);
  localparam int CW = $clog2(MAXW + 1);
  localparam logic [CW-1:0] MGMT_END = CW'(MGMT_CYC - 1);
  localparam logic [CW-1:0] ANA_END  = CW'(ANA_WAIT - 1);
  localparam logic [CW-1:0] LOCK_END = CW'(LOCK_WAIT - 1);

  typedef enum logic [2:0] {S_MGMT, S_CAL, S_ANA, S_LOCK, S_RUN} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [1:0] cal_q, lock_q, ref_q;
  logic cal_s, lock_s, ref_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= 2'b11;
      lock_q <= 2'b00;
      ref_q  <= 2'b00;
    end else begin
      cal_q  <= {cal_q[0], cal_busy_i};
      lock_q <= {lock_q[0], lock_data_i};
      ref_q  <= {ref_q[0], lock_ref_i};
    end
  end

  assign cal_s  = cal_q[1];
  assign lock_s = lock_q[1];
  assign ref_s  = ref_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_MGMT;
      cnt <= '0;
    end else if (reset_req_i) begin
      st  <= S_CAL;
      cnt <= '0;
    end else begin
      case (st)
        S_MGMT: begin
          if (cnt >= MGMT_END) begin
            st  <= S_CAL;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_CAL: begin
          cnt <= '0;
          if (!cal_s) st <= S_ANA;
        end
        S_ANA: begin
          if (cal_s) begin
            st  <= S_CAL;
            cnt <= '0;
          end else if (cnt >= ANA_END) begin
            st  <= S_LOCK;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_LOCK: begin
          if (!lock_s) cnt <= '0;
          else if (cnt >= LOCK_END) begin
            if (!cal_s) st <= S_RUN;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign mgmt_rst_o = (st == S_MGMT);
  assign ana_rst_o  = (st == S_MGMT) || (st == S_CAL) || (st == S_ANA);
  assign dig_rst_o  = (st != S_RUN);
  assign ready_o    = (st == S_RUN);

  // R1
  mgmt_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mgmt_rst_o) |-> $past(mgmt_rst_o, 2));

  // R3
  ana_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ana_rst_o) |-> (!$past(cal_s) && !$past(cal_s, 2)));

  // R4
  dig_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dig_rst_o) |-> ($past(lock_s) && $past(lock_s, 2)));

  // R6
  dig_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dig_rst_o) |-> (!$past(ana_rst_o) && !$past(cal_s)));

  // R7
  ref_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCK && lock_s && !ref_s && !reset_req_i) |=> (cnt != '0 || st == S_RUN));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_i |=> (ana_rst_o && dig_rst_o && !ready_o && !mgmt_rst_o));

  // R9
  ana_pairs_dig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ana_rst_o) |-> dig_rst_o);

  // R9
  ready_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!dig_rst_o && !ana_rst_o && !mgmt_rst_o));
endmodule

// File: tb/rx_rst_seq_tb.sv
module rx_rst_seq_tb;
  localparam int MGMT_CYC  = 3;
  localparam int ANA_WAIT  = 6;
  localparam int LOCK_WAIT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_req_i = 1'b0;
  logic cal_busy_i = 1'b1;
  logic lock_data_i = 1'b0;
  logic lock_ref_i = 1'b0;
  logic mgmt_rst_o, ana_rst_o, dig_rst_o, ready_o;

  int checks = 0;
  int errors = 0;
  int seed = 1234;

  always #5 clk = ~clk;

  rx_rst_seq #(.MGMT_CYC(MGMT_CYC), .ANA_WAIT(ANA_WAIT), .LOCK_WAIT(LOCK_WAIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .reset_req_i(reset_req_i), .cal_busy_i(cal_busy_i),
    .lock_data_i(lock_data_i), .lock_ref_i(lock_ref_i), .mgmt_rst_o(mgmt_rst_o),
    .ana_rst_o(ana_rst_o), .dig_rst_o(dig_rst_o), .ready_o(ready_o));

  function automatic int exp_ana_lat();
    return ANA_WAIT + 3;
  endfunction

  function automatic int exp_dig_lat();
    return LOCK_WAIT + 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    lock_ref_i = 1'($urandom(seed) & 1);
    seed = seed + 1;
  endtask

  task automatic measure_ana(output int n);
    n = 0;
    while (ana_rst_o && n < 500) begin tick(); n++; end
  endtask

  task automatic measure_dig(output int n);
    n = 0;
    while (dig_rst_o && n < 500) begin
      tick(); n++;
      chk(ready_o == !dig_rst_o, "R9", ready_o, !dig_rst_o);
    end
  endtask

  task automatic restart();
    reset_req_i = 1'b1;
    cal_busy_i = 1'b1;
    lock_data_i = 1'b0;
    tick();
    reset_req_i = 1'b0;
    chk(ana_rst_o && dig_rst_o && !ready_o, "R8", {ana_rst_o, dig_rst_o, ready_o}, 3'b110);
    chk(!mgmt_rst_o, "R8", mgmt_rst_o, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int h;
    int lo;
    #1;
    repeat (3) tick();
    chk(mgmt_rst_o && ana_rst_o && dig_rst_o && !ready_o, "R1/R2 reset state",
        {mgmt_rst_o, ana_rst_o, dig_rst_o, ready_o}, 4'b1110);
    rst_n = 1'b1;
    n = 0;
    while (mgmt_rst_o && n < 50) begin tick(); n++; end
    chk(n == MGMT_CYC, "R1 mgmt width", n, MGMT_CYC);
    repeat (20) begin
      tick();
      chk(ana_rst_o && dig_rst_o && !ready_o && !mgmt_rst_o, "R2 hold",
          {mgmt_rst_o, ana_rst_o, dig_rst_o, ready_o}, 4'b0110);
    end

    cal_busy_i = 1'b0;
    measure_ana(n);
    chk(n == exp_ana_lat(), "R3 analog latency", n, exp_ana_lat());
    chk(dig_rst_o, "R2 digital still held", dig_rst_o, 1);

    repeat (4) tick();
    lock_data_i = 1'b1;
    measure_dig(n);
    chk(n == exp_dig_lat(), "R4 digital latency", n, exp_dig_lat());
    repeat (30) begin
      tick();
      chk(ready_o && !ana_rst_o, "R7 run unaffected by lock_ref", ready_o, 1);
    end

    restart();
    cal_busy_i = 1'b0;
    tick(); tick();
    cal_busy_i = 1'b1;
    repeat (3) tick();
    cal_busy_i = 1'b0;
    measure_ana(n);
    chk(n == exp_ana_lat(), "R3 restart after cal glitch", n, exp_ana_lat());

    cal_busy_i = 1'b1;
    lock_data_i = 1'b1;
    repeat (LOCK_WAIT + 10) tick();
    chk(dig_rst_o && !ready_o, "R6 held while cal busy", dig_rst_o, 1);
    cal_busy_i = 1'b0;
    measure_dig(n);
    chk(n == 3, "R6 release after cal idle", n, 3);

    for (int t = 0; t < 20; t++) begin
      restart();
      repeat (1 + ($urandom(seed) % 8)) tick();
      cal_busy_i = 1'b0;
      measure_ana(n);
      chk(n == exp_ana_lat(), "R3 random", n, exp_ana_lat());
      for (int g = 0; g < 1 + int'($urandom(seed) % 4); g++) begin
        h = 1 + ($urandom(seed) % (LOCK_WAIT - 1));
        lo = 1 + ($urandom(seed) % 3);
        lock_data_i = 1'b1;
        repeat (h) tick();
        lock_data_i = 1'b0;
        repeat (lo) tick();
        chk(dig_rst_o, "R5 short lock pulse", dig_rst_o, 1);
      end
      lock_data_i = 1'b1;
      measure_dig(n);
      chk(n == exp_dig_lat(), "R4/R5/R7 random latency", n, exp_dig_lat());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule